// File: doc/BRIEF.md
# Single-Error-Correcting Protected Storage

This block keeps a small array of 8-bit words, each stored as a 12-bit Hamming codeword. A write encodes the data with four check bits. A read takes the stored codeword and recomputes the checks to form a syndrome. If the syndrome points at one of the twelve bit positions, the block inverts that bit, returns the repaired data and raises a one-cycle corrected-error flag. In the following cycle it writes the repaired codeword back to the same word. Syndromes that point past position 12 are reported as uncorrectable, and nothing is written back.

A client drives one address and separate write and read strobes. It must hold off new accesses while `busy` is high, because that cycle belongs to the repair write. A test input can invert any one stored bit of the addressed word, so that errors can be injected on purpose.

Top module: `hsec_mem`

## Requirements
- R1: Bit k of the codeword (k = 1..12, with bit k held at index k-1) is a check bit when k is 1, 2, 4 or 8. Data bits d0..d7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Check bit c is the XOR of all other positions whose index has the bit of c's position set. The syndrome therefore equals the XOR of the positions of all flipped bits.
- R2: A read accepted at clock edge N makes `rdata` valid, with `rvalid` high, for exactly the one cycle after edge N+1.
- R3: A read of a word with any single flipped data bit returns the original data with `err_corr` high and `err_uncorr` low.
- R4: A read of a word with a single flipped check bit (position 1, 2, 4 or 8) returns the data unchanged with `err_corr` high.
- R5: After a corrected read, the stored word is repaired, so a second read of it returns the data with no error flag.
- R6: `busy` is high only in the cycle after edge N of a read that finds a correctable error. Writes, reads and flips presented in that cycle are ignored.
- R7: A syndrome of 13, 14 or 15 raises `err_uncorr` and returns the uncorrected data bits. Nothing is written back, so a repeat read flags the same error again.
- R8: With `flip_en` high, the stored bit at position `flip_pos` (1..12) of word `addr` is inverted. Values 0 and 13..15 leave the word unchanged.
- R9: Reset clears all outputs and sets every word to the all-zero codeword, which reads back as data 0 with no error.
- R10: When strobes coincide, a write wins over a flip and a flip wins over a read. The strobes that lose have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address for all accesses |
| wdata | input | 8 | Write data |
| flip_en | input | 1 | Test strobe: invert one stored bit |
| flip_pos | input | 4 | Codeword position (1..12) to invert |
| rdata | output | 8 | Read data, corrected where possible |
| rvalid | output | 1 | Read data valid pulse |
| err_corr | output | 1 | Single error found and corrected |
| err_uncorr | output | 1 | Syndrome beyond position 12 |
| busy | output | 1 | Repair write in progress; accesses ignored |

## Verification
A read accepted at edge N makes `busy` visible after edge N, and `rdata`, `rvalid` and the error flags after edge N+1. They return low after edge N+2. The bench drives each strobe for one cycle on the falling edge. It then samples on the next three falling edges: first `busy` with `rvalid` still low, then the data and flags, then `rvalid` low again. A write or flip takes effect at the one edge it spans, so the read that follows it can start on the next falling edge.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    localparam int DATA_W = 8;
    localparam int CW_W   = 12;
    localparam int SYN_W  = 4;
    localparam int N_CHK  = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        cw_t   fixed_cw;
        logic  corr;
        logic  uncorr;
    } dec_t;

    // Position p (1-based) is a check position when p is a power of two.
    function automatic logic is_check_pos(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    // All codeword positions whose index has bit k set.
    function automatic cw_t cover_mask(input int k);
        cw_t m = '0;
        for (int p = 1; p <= CW_W; p++)
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        return m;
    endfunction

    function automatic cw_t scatter(input data_t d);
        cw_t c = '0;
        int  j = 0;
        for (int p = 1; p <= CW_W; p++)
            if (!is_check_pos(p)) begin
                c[p-1] = d[j];
                j = j + 1;
            end
        return c;
    endfunction

    function automatic data_t gather(input cw_t c);
        data_t d = '0;
        int    j = 0;
        for (int p = 1; p <= CW_W; p++)
            if (!is_check_pos(p)) begin
                d[j] = c[p-1];
                j = j + 1;
            end
        return d;
    endfunction

    function automatic cw_t encode(input data_t d);
        cw_t c = scatter(d);
        for (int k = 0; k < N_CHK; k++)
            c[(1 << k) - 1] = ^(c & cover_mask(k));
        return c;
    endfunction

    function automatic syn_t syndrome(input cw_t c);
        syn_t s = '0;
        for (int k = 0; k < N_CHK; k++)
            s[k] = ^(c & cover_mask(k));
        return s;
    endfunction

endpackage

// File: rtl/hsec_encode.sv
module hsec_encode
    import hsec_pkg::*;
(
    input  data_t data,
    output cw_t   cw
);
    always_comb cw = encode(data);
endmodule

// File: rtl/hsec_decode.sv
module hsec_decode
    import hsec_pkg::*;
(
    input  cw_t  cw,
    output dec_t dec
);
    syn_t syn;
    int   pos;

    always_comb begin
        syn          = syndrome(cw);
        pos          = int'(syn);
        dec.fixed_cw = cw;
        dec.corr     = 1'b0;
        dec.uncorr   = 1'b0;
        if (pos >= 1 && pos <= CW_W) begin
            dec.fixed_cw[pos-1] = ~cw[pos-1];
            dec.corr            = 1'b1;
        end else if (pos > CW_W) begin
            dec.uncorr = 1'b1;
        end
        dec.data = gather(dec.fixed_cw);
    end
endmodule

// File: rtl/hsec_store.sv
module hsec_store
    import hsec_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cw_t           wcw,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  syn_t          flip_pos,
    input  logic [AW-1:0] raddr,
    output cw_t           rcw
);
    localparam syn_t LAST_POS = SYN_W'(CW_W);

    cw_t  words [DEPTH];
    logic flip_ok;

    assign flip_ok = flip_en && (flip_pos != '0) && (flip_pos <= LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wcw;
        end else if (flip_ok) begin
            words[flip_addr][flip_pos - 4'd1] <= ~words[flip_addr][flip_pos - 4'd1];
        end
    end

    assign rcw = words[raddr];
endmodule

// File: rtl/hsec_mem.sv
module hsec_mem
    import hsec_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          flip_en,
    input  logic [3:0]    flip_pos,
    output logic [7:0]    rdata,
    output logic          rvalid,
    output logic          err_corr,
    output logic          err_uncorr,
    output logic          busy
);
    logic          wr_acc, fl_acc, rd_acc;
    logic          rd_pend;
    logic [AW-1:0] rd_addr_q;
    cw_t           rd_cw_q;
    cw_t           enc_cw, st_rcw, st_wcw;
    logic [AW-1:0] st_waddr;
    dec_t          dec;

    // A repair write owns the cycle; then write > flip > read.
    assign busy   = rd_pend && dec.corr;
    assign wr_acc = wr_en && !busy;
    assign fl_acc = flip_en && !busy && !wr_en;
    assign rd_acc = rd_en && !busy && !wr_en && !flip_en;

    assign st_waddr = busy ? rd_addr_q : addr;
    assign st_wcw   = busy ? dec.fixed_cw : enc_cw;

    hsec_encode u_enc (
        .data (wdata),
        .cw   (enc_cw)
    );

    hsec_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (busy || wr_acc),
        .waddr     (st_waddr),
        .wcw       (st_wcw),
        .flip_en   (fl_acc),
        .flip_addr (addr),
        .flip_pos  (flip_pos),
        .raddr     (addr),
        .rcw       (st_rcw)
    );

    hsec_decode u_dec (
        .cw  (rd_cw_q),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend    <= 1'b0;
            rd_addr_q  <= '0;
            rd_cw_q    <= '0;
            rdata      <= '0;
            rvalid     <= 1'b0;
            err_corr   <= 1'b0;
            err_uncorr <= 1'b0;
        end else begin
            rd_pend    <= rd_acc;
            if (rd_acc) begin
                rd_addr_q <= addr;
                rd_cw_q   <= st_rcw;
            end
            rvalid     <= rd_pend;
            err_corr   <= rd_pend && dec.corr;
            err_uncorr <= rd_pend && dec.uncorr;
            if (rd_pend) rdata <= dec.data;
        end
    end
endmodule

// File: rtl/hsec_mem_chk.sv
module hsec_mem_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic flip_en,
    input logic rvalid,
    input logic err_corr,
    input logic err_uncorr,
    input logic busy
);
    logic rd_acc;
    assign rd_acc = rd_en && !busy && !wr_en && !flip_en;

    a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> ##2 rvalid);

    a_r3_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        (err_corr || err_uncorr) |-> rvalid);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_corr && err_uncorr));

    a_r6_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r6_busy_from_read: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(rd_acc));

    a_r6_busy_then_corr: assert property (@(posedge clk) disable iff (rst)
        busy |=> err_corr);

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rvalid && !busy && !err_corr && !err_uncorr));
endmodule

bind hsec_mem hsec_mem_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .flip_en    (flip_en),
    .rvalid     (rvalid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .busy       (busy)
);

// File: tb/test_hsec_mem.sv
`timescale 1ns/1ps
module test_hsec_mem;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, flip_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [3:0] flip_pos = '0;
    logic [7:0] rdata;
    logic       rvalid, err_corr, err_uncorr, busy;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    hsec_mem #(.DEPTH(16)) i_hsec_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .flip_en(flip_en), .flip_pos(flip_pos), .rdata(rdata),
        .rvalid(rvalid), .err_corr(err_corr), .err_uncorr(err_uncorr), .busy(busy)
    );

    // {addr, data, flip position}
    localparam logic [15:0] VEC [14] = '{
        16'h0_00_0, 16'h1_A5_1, 16'h2_3C_2, 16'h3_FF_3, 16'h4_81_4,
        16'h5_5A_5, 16'h6_C3_6, 16'h7_0F_7, 16'h8_F0_8, 16'h9_96_9,
        16'hA_69_A, 16'hB_12_B, 16'hC_7E_C, 16'hD_E4_D
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_flip(input logic [3:0] a, input logic [3:0] p);
        @(negedge clk); addr = a; flip_pos = p; flip_en = 1'b1;
        @(negedge clk); flip_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d, output logic c,
                           output logic u, output logic b);
        logic v0, v1, v2;
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; b = busy; v0 = rvalid;
        @(negedge clk); d = rdata; c = err_corr; u = err_uncorr; v1 = rvalid;
        @(negedge clk); v2 = rvalid;
        chk("R2", "rvalid before", int'(v0), 0);
        chk("R2", "rvalid due", int'(v1), 1);
        chk("R2", "rvalid after", int'(v2), 0);
    endtask

    initial begin
        logic [7:0] d;
        logic c, u, b;

        repeat (3) @(negedge clk);
        chk("R9", "rvalid in reset", int'(rvalid), 0);
        chk("R9", "busy in reset", int'(busy), 0);
        chk("R9", "rdata in reset", int'(rdata), 0);
        chk("R9", "flags in reset", int'({err_corr, err_uncorr}), 0);
        rst = 1'b0;
        do_read(4'd5, d, c, u, b);
        chk("R9", "reset word data", int'(d), 0);
        chk("R9", "reset word flags", int'({c, u}), 0);

        // Table walk: write, optional flip, read, re-read.
        for (int i = 0; i < 14; i++) begin
            logic [3:0] va, vp;
            logic [7:0] vd;
            logic       hit;
            va  = VEC[i][15:12];
            vd  = VEC[i][11:4];
            vp  = VEC[i][3:0];
            hit = (vp >= 4'd1) && (vp <= 4'd12);
            do_write(va, vd);
            if (vp != 4'd0) do_flip(va, vp);
            do_read(va, d, c, u, b);
            if (vp == 4'd1 || vp == 4'd2 || vp == 4'd4 || vp == 4'd8)
                chk("R4", "check-bit flip data", int'(d), int'(vd));
            else
                chk("R3", "read data", int'(d), int'(vd));
            chk(hit ? "R3" : "R8", "err_corr", int'(c), int'(hit));
            chk("R3", "err_uncorr", int'(u), 0);
            chk("R6", "busy on read", int'(b), int'(hit));
            do_read(va, d, c, u, b);
            chk("R5", "scrubbed data", int'(d), int'(vd));
            chk("R5", "scrubbed flags", int'({c, u, b}), 0);
        end

        // R7: flips at 1 and 12 give syndrome 13; d7 stays inverted.
        do_write(4'd14, 8'h5A);
        do_flip(4'd14, 4'd1);
        do_flip(4'd14, 4'd12);
        do_read(4'd14, d, c, u, b);
        chk("R7", "uncorr flag", int'(u), 1);
        chk("R7", "corr flag", int'(c), 0);
        chk("R7", "busy", int'(b), 0);
        chk("R7", "raw data", int'(d), 8'hDA);
        do_read(4'd14, d, c, u, b);
        chk("R7", "no writeback", int'(u), 1);

        // R1: flips at 3 and 5 give syndrome 6, so d2 is wrongly inverted too.
        do_write(4'd15, 8'h00);
        do_flip(4'd15, 4'd3);
        do_flip(4'd15, 4'd5);
        do_read(4'd15, d, c, u, b);
        chk("R1", "layout miscorrect data", int'(d), 8'h07);
        chk("R1", "layout miscorrect flag", int'(c), 1);

        // R6: a write presented during the repair cycle is dropped.
        do_write(4'd1, 8'h3C);
        do_write(4'd2, 8'h96);
        do_flip(4'd1, 4'd7);
        @(negedge clk); addr = 4'd1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R6", "busy seen", int'(busy), 1);
        addr = 4'd2; wdata = 8'hFF; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        chk("R6", "repaired data", int'(rdata), 8'h3C);
        chk("R6", "corr flag", int'(err_corr), 1);
        do_read(4'd2, d, c, u, b);
        chk("R6", "write during busy ignored", int'(d), 8'h96);

        // R10: write + flip + read together: write only.
        @(negedge clk); addr = 4'd3; wdata = 8'hA5; wr_en = 1'b1; flip_en = 1'b1;
        flip_pos = 4'd3; rd_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; flip_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        chk("R10", "read lost to write", int'(rvalid), 0);
        do_read(4'd3, d, c, u, b);
        chk("R10", "write data", int'(d), 8'hA5);
        chk("R10", "flip lost to write", int'(c), 0);

        // R10: flip + read together: flip only.
        @(negedge clk); addr = 4'd3; flip_en = 1'b1; flip_pos = 4'd9; rd_en = 1'b1;
        @(negedge clk); flip_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        chk("R10", "read lost to flip", int'(rvalid), 0);
        do_read(4'd3, d, c, u, b);
        chk("R8", "flip applied", int'(c), 1);
        chk("R8", "flip corrected data", int'(d), 8'hA5);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule